// File: doc/BRIEF.md
# Floating-point vector maximum reduction

This block takes a packed vector of floating-point elements and returns the largest element as one scalar of element width. It has two precisions. In half precision the elements are 16 bits wide and the vector holds four or eight of them. In single precision the elements are 32 bits wide and the vector always holds four of them. Operands are accepted on a valid strobe, one per clock if needed. The scalar result, an illegal-shape flag and a trap request come out one clock later.

Every pairwise comparison uses maximum-number rules. A quiet NaN loses to any number. Two NaNs give the canonical default NaN. Positive zero ranks above negative zero. A signaling NaN raises the invalid-operation exception and is then handled as a quiet NaN. When the flush control is set, subnormal inputs are replaced by zeros of the same sign and the input-denormal exception is raised. For each exception, a per-exception enable decides what happens. If the enable is clear, the exception is logged in a sticky flag. If it is set, the block raises a trap request instead.

Top module: `fp_vmax_reduce`

## Requirements
- R1: With `prec_single`=0, lanes are 16 bits, and lane k sits at `operand[16k+15:16k]`. With `wide`=0 only lanes 0 to 3 (`operand[63:0]`) take part; with `wide`=1 lanes 0 to 7 take part. With `prec_single`=1 and `wide`=1, lanes are 32 bits and lane k sits at `operand[32k+31:32k]`, k = 0 to 3. Lanes that do not take part have no effect on the result or on the exceptions.
- R2: The shape `prec_single`=1 with `wide`=0 is illegal. An accepted operand of that shape drives `undef_cfg` to 1 and `result` to 0, sets no sticky flag and raises no trap.
- R3: For a legal shape, `result` holds the bit pattern of the largest participating lane. In half precision it is placed in `result[15:0]` and `result[31:16]` is 0.
- R4: A quiet NaN lane loses to any number. If every participating lane is a NaN, the result is the default NaN: 16'h7E00 in half precision and 32'h7FC00000 in single precision.
- R5: A participating signaling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0) raises the invalid exception, which is bit 0 of the exception vector. The lane then counts as a quiet NaN.
- R6: Positive zero ranks above negative zero, so a vector containing both zeros and nothing larger returns positive zero.
- R7: With `flush`=1, a participating subnormal is replaced by a zero of its sign and raises the input-denormal exception, which is bit 1 of the exception vector. With `flush`=0, subnormals are compared by their exact value and raise nothing.
- R8: For each raised exception bit e: if `trap_en[e]`=0 the exception goes to `sticky_flags[e]`; if `trap_en[e]`=1, `trap_req` pulses high in the result cycle and `sticky_flags[e]` is not set by it.
- R9: `out_valid`, `result`, `undef_cfg` and `trap_req` are registered. They follow an operand one clock after the strobe, and an operand may be presented on every clock. When `in_valid` is low, no trap and no illegal-shape flag appear in the following cycle.
- R10: `sticky_flags` only gains bits until `flag_clr` is pulsed. A clear empties the flags on the next clock, but exceptions raised in the clearing cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 128 | Packed vector of lanes |
| prec_single | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| wide | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| trap_en | input | 2 | Per-exception trap enable (bit 0 invalid, bit 1 input-denormal) |
| flush | input | 1 | Replace subnormal inputs by signed zeros |
| flag_clr | input | 1 | Empty the sticky flags |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | 32 | Largest lane, zero-extended in half precision |
| undef_cfg | output | 1 | Illegal precision/width shape was presented |
| sticky_flags | output | 2 | Sticky exception flags (bit 0 invalid, bit 1 input-denormal) |
| trap_req | output | 1 | Trap request for an enabled exception |

## Verification
The bench sweeps a table of special half-precision and single-precision values across every lane position, in both vector widths and both flush settings, and compares the results with an arithmetic reference model. The values cover both zeros, subnormals, infinities and both kinds of NaN. A design that used plain maximum would let a NaN win or return a NaN payload. A design that compared raw bits would rank negative numbers upside down or return negative zero. One that ignored the narrow shape would let the large values placed in lanes 4 to 7 through.

Directed vectors check that exceptions are routed correctly. A design that set a sticky flag for an enabled trap would fail. So would one that lost an exception raised in the same cycle as a clear, or one that raised flags for an illegal shape. The back-to-back stream catches any extra pipeline stage.

// File: rtl/fp_vmax_pkg.sv
// Shared constants for the vector maximum reduction.
// Assumes IEEE-style binary formats: sign, biased exponent, fraction.
package fp_vmax_pkg;
    localparam int HALF_EXP = 5;
    localparam int HALF_MAN = 10;
    localparam int SGL_EXP  = 8;
    localparam int SGL_MAN  = 23;
    localparam int EXC_W    = 2;
    localparam int EXC_INV  = 0;
    localparam int EXC_DEN  = 1;
    typedef logic [EXC_W-1:0] exc_t;
endpackage

// File: rtl/fp_lane_prep.sv
// Classifies one lane before comparison.
// Does: flush of subnormals to a signed zero, NaN detection, signaling-NaN detection.
// Assumes: an inactive lane is presented to the tree as a NaN and raises nothing.
module fp_lane_prep #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] raw,
    input  logic         active,
    input  logic         flush,
    output logic [W-1:0] val,
    output logic         is_nan,
    output logic         snan,
    output logic         den
);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             nan_raw;

    // Field split and classification of the lane.
    always_comb begin
        sgn     = raw[W-1];
        ex      = raw[MAN_W +: EXP_W];
        mn      = raw[MAN_W-1:0];
        nan_raw = (&ex) && (|mn);
        snan    = active && nan_raw && !mn[MAN_W-1];
        den     = active && flush && (ex == '0) && (|mn);
        is_nan  = !active || nan_raw;
        val     = den ? {sgn, {(W-1){1'b0}}} : raw;
    end
endmodule

// File: rtl/fp_max2.sv
// Two-input maximum-number comparator.
// Does: NaN loses to a number; two NaNs give the default NaN; +0 ranks above -0.
// Assumes: NaN flags come from fp_lane_prep or from a lower comparator.
module fp_max2 #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a,
    input  logic         a_nan,
    input  logic [W-1:0] b,
    input  logic         b_nan,
    output logic [W-1:0] y,
    output logic         y_nan
);
    localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0] ka, kb;

    // Map sign-magnitude onto an unsigned total order and choose the winner.
    always_comb begin
        ka = a[W-1] ? ~a : {1'b1, a[W-2:0]};
        kb = b[W-1] ? ~b : {1'b1, b[W-2:0]};
        if (a_nan && b_nan) begin
            y     = DNAN;
            y_nan = 1'b1;
        end else if (a_nan) begin
            y     = b;
            y_nan = 1'b0;
        end else if (b_nan) begin
            y     = a;
            y_nan = 1'b0;
        end else begin
            y     = (kb > ka) ? b : a;
            y_nan = 1'b0;
        end
    end
endmodule

// File: rtl/fp_max_tree.sv
// Balanced pairwise maximum tree over LANES lanes.
// Does: adjacent lanes are compared first, then pair winners, down to one value.
// Assumes: LANES is a power of two; heap indexing, node i takes children 2i+1, 2i+2.
module fp_max_tree #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    parameter int LANES = 8,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int NODES = 2 * LANES - 1
) (
    input  logic [LANES*W-1:0] lanes,
    input  logic [LANES-1:0]   active,
    input  logic               flush,
    output logic [W-1:0]       max_val,
    output logic               inv,
    output logic               den
);
    localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [NODES-1:0][W-1:0] nv;
    logic [NODES-1:0]        nn;
    logic [LANES-1:0]        sn;
    logic [LANES-1:0]        dn;

    for (genvar k = 0; k < LANES; k++) begin : g_leaf
        fp_lane_prep #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_prep (
            .raw    (lanes[k*W +: W]),
            .active (active[k]),
            .flush  (flush),
            .val    (nv[LANES-1+k]),
            .is_nan (nn[LANES-1+k]),
            .snan   (sn[k]),
            .den    (dn[k])
        );
    end

    for (genvar i = 0; i < LANES - 1; i++) begin : g_node
        fp_max2 #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
            .a     (nv[2*i+1]),
            .a_nan (nn[2*i+1]),
            .b     (nv[2*i+2]),
            .b_nan (nn[2*i+2]),
            .y     (nv[i]),
            .y_nan (nn[i])
        );
    end

    // Root value and lane exception summary.
    always_comb begin
        max_val = nn[0] ? DNAN : nv[0];
        inv     = |sn;
        den     = |dn;
    end
endmodule

// File: rtl/fp_vmax_reduce.sv
// Vector maximum reduction, top level.
// Does: runs a half-precision and a single-precision tree side by side, selects by
// precision, registers result/flags/trap one clock after the strobe.
// Assumes: VEC_W holds a whole number of lanes of each precision; single precision is
// legal only in the full-width shape.
module fp_vmax_reduce #(
    parameter int H_EXP = fp_vmax_pkg::HALF_EXP,
    parameter int H_MAN = fp_vmax_pkg::HALF_MAN,
    parameter int S_EXP = fp_vmax_pkg::SGL_EXP,
    parameter int S_MAN = fp_vmax_pkg::SGL_MAN,
    parameter int VEC_W = 128,
    localparam int HW      = 1 + H_EXP + H_MAN,
    localparam int SW      = 1 + S_EXP + S_MAN,
    localparam int H_LANES = VEC_W / HW,
    localparam int S_LANES = VEC_W / SW,
    localparam int EXC_W   = fp_vmax_pkg::EXC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] operand,
    input  logic             prec_single,
    input  logic             wide,
    input  logic [EXC_W-1:0] trap_en,
    input  logic             flush,
    input  logic             flag_clr,
    output logic             out_valid,
    output logic [SW-1:0]    result,
    output logic             undef_cfg,
    output logic [EXC_W-1:0] sticky_flags,
    output logic             trap_req
);
    import fp_vmax_pkg::*;

    logic [H_LANES-1:0] h_act;
    logic [HW-1:0]      h_max;
    logic               h_inv, h_den;
    logic [SW-1:0]      s_max;
    logic               s_inv, s_den;
    logic               illegal;
    exc_t               exc_now;
    logic [SW-1:0]      res_now;

    fp_max_tree #(.EXP_W(H_EXP), .MAN_W(H_MAN), .LANES(H_LANES)) u_half (
        .lanes   (operand[H_LANES*HW-1:0]),
        .active  (h_act),
        .flush   (flush),
        .max_val (h_max),
        .inv     (h_inv),
        .den     (h_den)
    );

    fp_max_tree #(.EXP_W(S_EXP), .MAN_W(S_MAN), .LANES(S_LANES)) u_single (
        .lanes   (operand[S_LANES*SW-1:0]),
        .active  ({S_LANES{1'b1}}),
        .flush   (flush),
        .max_val (s_max),
        .inv     (s_inv),
        .den     (s_den)
    );

    // Shape decode, exception gathering and result selection.
    always_comb begin
        h_act   = wide ? {H_LANES{1'b1}}
                       : {{(H_LANES/2){1'b0}}, {(H_LANES/2){1'b1}}};
        illegal = prec_single && !wide;
        exc_now = '0;
        if (in_valid && !illegal) begin
            exc_now[EXC_INV] = prec_single ? s_inv : h_inv;
            exc_now[EXC_DEN] = prec_single ? s_den : h_den;
        end
        if (illegal)          res_now = '0;
        else if (prec_single) res_now = s_max;
        else                  res_now = {{(SW-HW){1'b0}}, h_max};
    end

    // Output register stage and sticky flag accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            undef_cfg    <= 1'b0;
            sticky_flags <= '0;
            trap_req     <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            undef_cfg    <= in_valid && illegal;
            trap_req     <= |(exc_now & trap_en);
            sticky_flags <= (flag_clr ? '0 : sticky_flags) | (exc_now & ~trap_en);
            if (in_valid) result <= res_now;
        end
    end
endmodule

// File: rtl/fp_vmax_checks.sv
// Protocol checks for fp_vmax_reduce, attached by bind.
// Assumes: default parameters (32-bit result, two exception bits).
module fp_vmax_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        prec_single,
    input logic        wide,
    input logic [1:0]  trap_en,
    input logic        flag_clr,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        undef_cfg,
    input logic [1:0]  sticky_flags,
    input logic        trap_req
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap_req && !undef_cfg));

    p_bad_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prec_single && !wide && !flag_clr)
        |=> (undef_cfg && result == 32'h0 && !trap_req && $stable(sticky_flags)));

    p_half_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !prec_single) |=> (result[31:16] == 16'h0));

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> (sticky_flags == 2'b00));

    p_trap_not_logged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flag_clr && trap_en == 2'b11) |=> $stable(sticky_flags));
endmodule

bind fp_vmax_reduce fp_vmax_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .prec_single  (prec_single),
    .wide         (wide),
    .trap_en      (trap_en),
    .flag_clr     (flag_clr),
    .out_valid    (out_valid),
    .result       (result),
    .undef_cfg    (undef_cfg),
    .sticky_flags (sticky_flags),
    .trap_req     (trap_req)
);

// File: tb/sim_fp_vmax_reduce.sv
// Self-checking bench: special-value sweeps plus random vectors against an arithmetic model.
module sim_fp_vmax_reduce;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic         prec_single = 1'b0;
    logic         wide = 1'b0;
    logic [1:0]   trap_en = 2'b00;
    logic         flush = 1'b0;
    logic         flag_clr = 1'b0;
    logic         out_valid;
    logic [31:0]  result;
    logic         undef_cfg;
    logic [1:0]   sticky_flags;
    logic         trap_req;

    int total = 0;
    int bad = 0;

    bit          pend = 0;
    logic [31:0] e_result = '0;
    bit          e_undef = 0, e_trap = 0, e_valid = 0;
    logic [1:0]  e_sticky = 2'b00;
    string       e_tag = "";
    bit          lit_pend = 0;
    logic [31:0] lit_val = '0;
    string       lit_tag = "";
    logic [31:0] lfsr = 32'h1234_5678;

    logic [15:0] hl [16] = '{16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h03FF, 16'h3C00,
                             16'hBC00, 16'h7BFF, 16'hFBFF, 16'h7C00, 16'hFC00, 16'h7E00,
                             16'h7C01, 16'hFE00, 16'h0400, 16'h3555};
    logic [31:0] sl [16] = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001,
                             32'h007F_FFFF, 32'h3F80_0000, 32'hBF80_0000, 32'h7F7F_FFFF,
                             32'hFF7F_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000,
                             32'h7F80_0001, 32'hFFC0_0000, 32'h0080_0000, 32'h4049_0FDB};

    fp_vmax_reduce u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .prec_single(prec_single), .wide(wide), .trap_en(trap_en), .flush(flush),
        .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
        .undef_cfg(undef_cfg), .sticky_flags(sticky_flags), .trap_req(trap_req)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic real lane_real(input logic [31:0] x, input int ew, input int mw);
        int  bias = (1 << (ew - 1)) - 1;
        int  e    = int'((x >> mw) & ((32'd1 << ew) - 1));
        real m    = real'(x & ((32'd1 << mw) - 1));
        real r;
        if (e == (1 << ew) - 1) r = 1.0e300;
        else if (e == 0)        r = m * 2.0 ** (1 - bias - mw);
        else                    r = (2.0 ** mw + m) * 2.0 ** (e - bias - mw);
        return x[ew + mw] ? -r : r;
    endfunction

    // Reference: sequential scan over the participating lanes (R1, R3-R7, R2).
    task automatic model(input logic [127:0] op, input bit sgl, input bit wd, input bit fl,
                         output logic [31:0] r, output bit inv, output bit den, output bit undef);
        int  ew, mw, n, w;
        bit  found = 0;
        real best = 0.0;
        logic [31:0] bb = '0;
        undef = sgl && !wd;
        r = '0; inv = 0; den = 0;
        if (undef) return;
        ew = sgl ? 8 : 5;
        mw = sgl ? 23 : 10;
        w  = 1 + ew + mw;
        n  = sgl ? 4 : (wd ? 8 : 4);
        for (int k = 0; k < n; k++) begin
            logic [31:0] x, m;
            int  e;
            bit  s;
            real v;
            x = sgl ? op[32*k +: 32] : {16'h0, op[16*k +: 16]};
            e = int'((x >> mw) & ((32'd1 << ew) - 1));
            m = x & ((32'd1 << mw) - 1);
            s = x[w-1];
            if (e == (1 << ew) - 1 && m != 0) begin
                if (!m[mw-1]) inv = 1;
                continue;
            end
            if (fl && e == 0 && m != 0) begin
                den = 1;
                x = 32'(s) << (w - 1);
            end
            v = lane_real(x, ew, mw);
            if (!found || v > best || (v == best && bb[w-1] && !s)) begin
                found = 1;
                best  = v;
                bb    = x;
            end
        end
        r = found ? bb : (sgl ? 32'h7FC0_0000 : 32'h0000_7E00);
    endtask

    task automatic check_prev();
        if (pend) begin
            chk(out_valid == e_valid, "R9 valid", 32'(out_valid), 32'(e_valid));
            chk(undef_cfg == e_undef, "R2 undef", 32'(undef_cfg), 32'(e_undef));
            chk(trap_req == e_trap, "R8 trap", 32'(trap_req), 32'(e_trap));
            chk(sticky_flags == e_sticky, "R10 sticky", 32'(sticky_flags), 32'(e_sticky));
            chk(result == e_result, e_tag, result, e_result);
            if (lit_pend) begin
                chk(result == lit_val, lit_tag, result, lit_val);
                lit_pend = 0;
            end
        end
    endtask

    task automatic step(input logic [127:0] op, input bit sgl, input bit wd, input bit fl,
                        input logic [1:0] te, input bit clr, input bit vld, input string tag);
        logic [31:0] r;
        bit inv, den, und;
        logic [1:0] exc;
        @(negedge clk);
        check_prev();
        operand = op; prec_single = sgl; wide = wd; flush = fl;
        trap_en = te; flag_clr = clr; in_valid = vld;
        model(op, sgl, wd, fl, r, inv, den, und);
        exc      = (vld && !und) ? {den, inv} : 2'b00;
        e_valid  = vld;
        e_undef  = vld && und;
        e_trap   = |(exc & te);
        e_sticky = (clr ? 2'b00 : e_sticky) | (exc & ~te);
        if (vld) e_result = und ? 32'h0 : r;
        e_tag = tag;
        pend  = 1;
    endtask

    task automatic lit(input logic [31:0] v, input string tag);
        lit_pend = 1; lit_val = v; lit_tag = tag;
    endtask

    function automatic logic [31:0] nextr(input logic [31:0] s);
        logic [31:0] t = s;
        t ^= t << 13; t ^= t >> 17; t ^= t << 5;
        return t;
    endfunction

    initial begin
        #(PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !trap_req && !undef_cfg, "R9 reset outputs", {out_valid, trap_req, undef_cfg}, 0);
        chk(sticky_flags == 2'b00, "R10 reset sticky", 32'(sticky_flags), 0);

        // R6: zeros of both signs
        step({64'h0, 16'h8000, 16'h8000, 16'h0000, 16'h8000}, 0, 0, 0, 2'b00, 0, 1, "R6 half zeros");
        lit(32'h0, "R6 half +0 wins");
        step({32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000}, 1, 1, 0, 2'b00, 0, 1, "R6 single zeros");
        lit(32'h0, "R6 single +0 wins");
        // R4: all NaN and NaN versus number
        step({64'h0, 16'h7E00, 16'hFE00, 16'h7E55, 16'h7E00}, 0, 0, 0, 2'b00, 0, 1, "R4 all qNaN");
        lit(32'h7E00, "R4 default NaN half");
        step({64'h0, 16'h7E00, 16'h3C00, 16'hFE00, 16'h7E00}, 0, 0, 0, 2'b00, 0, 1, "R4 qNaN loses");
        lit(32'h3C00, "R4 number wins");
        step({4{32'h7FC0_0000}}, 1, 1, 0, 2'b00, 0, 1, "R4 single all NaN");
        lit(32'h7FC0_0000, "R4 default NaN single");
        // R5: signaling NaN logs invalid
        step({64'h0, 16'h7E00, 16'hFC00, 16'hBC00, 16'h7C01}, 0, 0, 0, 2'b00, 0, 1, "R5 sNaN quieted");
        lit(32'hBC00, "R5 result");
        // R8: enabled trap, after clearing
        step('0, 0, 0, 0, 2'b00, 1, 0, "R10 clear");
        step({64'h0, 16'h7E00, 16'hFC00, 16'hBC00, 16'h7C01}, 0, 0, 0, 2'b01, 0, 1, "R8 trap not logged");
        // R7: flush and exact compare
        step({64'h0, 16'hFC00, 16'h8001, 16'hBC00, 16'h0001}, 0, 0, 1, 2'b00, 0, 1, "R7 flush");
        lit(32'h0, "R7 flushed to +0");
        step({64'h0, 16'hFC00, 16'h8001, 16'hBC00, 16'h0001}, 0, 0, 0, 2'b00, 0, 1, "R7 exact");
        lit(32'h0001, "R7 subnormal kept");
        // R2: illegal shape
        step({4{32'h7F80_0001}}, 1, 0, 1, 2'b00, 0, 1, "R2 illegal shape");
        // R1: narrow shape ignores upper lanes, including a sNaN there
        step({16'h7BFF, 16'h7C01, 16'h7BFF, 16'h7BFF, 16'h3C00, 16'h0000, 16'hBC00, 16'h3555}, 0, 0, 0, 2'b00, 1, 1, "R1 narrow");
        lit(32'h3C00, "R1 upper lanes ignored");
        step({16'h7BFF, 16'h7E00, 16'h7BFF, 16'h7BFF, 16'h3C00, 16'h0000, 16'hBC00, 16'h3555}, 0, 1, 0, 2'b00, 0, 1, "R1 wide");
        lit(32'h7BFF, "R1 upper lanes used");
        // R10: clear in the same cycle as a new exception
        step({64'h0, 16'h7C01, 16'h0, 16'h0, 16'h0}, 0, 0, 0, 2'b00, 1, 1, "R10 clear with new exception");

        // R3/R4/R6/R7 sweep of special half values over all lane positions
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int m = 0; m < 4; m++) begin
                    logic [127:0] op = '0;
                    for (int k = 0; k < 8; k++) op[16*k +: 16] = hl[(i + j*k + k*k) & 15];
                    step(op, 0, m[0], m[1], 2'(i + j), (i == 0 && j == 0), 1, "R3 half sweep");
                end
        // single precision sweep
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int f = 0; f < 2; f++) begin
                    logic [127:0] op = '0;
                    for (int k = 0; k < 4; k++) op[32*k +: 32] = sl[(i + j*k + 3*k*k) & 15];
                    step(op, 1, 1, f[0], 2'(j), 0, 1, "R3 single sweep");
                end
        // random stream, mixed shapes and idle cycles
        for (int t = 0; t < 3000; t++) begin
            logic [127:0] op;
            logic [31:0] ctl;
            for (int k = 0; k < 4; k++) begin
                lfsr = nextr(lfsr);
                op[32*k +: 32] = lfsr;
                if (lfsr[3:0] == 4'h0) op[32*k + 23 +: 8] = 8'hFF;
                if (lfsr[3:0] == 4'h1) op[32*k + 23 +: 8] = 8'h00;
                if (lfsr[7:4] == 4'h2) op[32*k + 10 +: 5] = 5'h1F;
                if (lfsr[7:4] == 4'h3) op[32*k + 10 +: 5] = 5'h00;
            end
            lfsr = nextr(lfsr);
            ctl = lfsr;
            step(op, ctl[0], ctl[1] | (ctl[5:2] != 0), ctl[6], ctl[8:7],
                 ctl[15:12] == 0, ctl[19:16] != 0, "R3 random");
        end
        step('0, 0, 0, 0, 2'b00, 0, 0, "R9 drain");
        @(negedge clk);
        check_prev();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule